// File: doc/BRIEF.md
# Push-Button Up/Down/Load Counter

This block keeps an 8-bit count that four push buttons and a bank of eight switches control. One button adds one to the count and another subtracts one. A third button copies the switch value into the count, and a fourth sets the count to zero. Each button passes through a two-flop synchronizer and a debounce filter. The filter accepts a new level only after the input has held it for a set number of clock cycles. A rising-edge detector then turns each accepted press into a single-cycle command, so one press changes the count once, however long the button is held.

The count is presented in binary and as three BCD digits (hundreds, tens, units), ready for a multiplexed digit display. A combinational shift-and-add-three network forms the BCD digits. The chip-level reset is asynchronous and active low. Inside the block its release is synchronized to the clock.

Top module: `pbtn_counter`

## Requirements
- R1: While the reset input is low, and after it is released, the count is 0 and all three BCD digits read 0 until a button press is accepted.
- R2: One accepted press of the up button raises the count by exactly one, however long the button is held.
- R3: One accepted press of the down button lowers the count by exactly one.
- R4: The count wraps from 255 to 0 on an up press and from 0 to 255 on a down press.
- R5: One accepted press of the load button sets the count to the value on the 8-bit switch input, sampled in the cycle the press is accepted.
- R6: One accepted press of the clear button sets the count to 0.
- R7: A button level is accepted only after the synchronized input has held it for DEBOUNCE_CYCLES consecutive cycles. A shorter pulse leaves the count unchanged.
- R8: Commands accepted in the same cycle are resolved in this order: clear first, then load, then up, then down. Only the winning command acts.
- R9: The hundreds, tens and units outputs are the decimal digits of the count, each in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_i | input | 1 | Raw count-up button, active high |
| btn_down_i | input | 1 | Raw count-down button, active high |
| btn_load_i | input | 1 | Raw load-from-switches button, active high |
| btn_clr_i | input | 1 | Raw clear button, active high |
| sw_i | input | 8 | Switch value used by the load command |
| count_o | output | 8 | Binary count |
| bcd_hund_o | output | 4 | BCD hundreds digit |
| bcd_tens_o | output | 4 | BCD tens digit |
| bcd_ones_o | output | 4 | BCD units digit |

## Verification
The hardest case to reach from the ports is two commands accepted in exactly the same cycle. That requires two debounced presses whose filters finish together. The bench changes both raw buttons on the same clock edge and holds them for the same time. Both filter paths have the same length, so their edge pulses coincide and the priority order decides the result. The converter is covered by loading each of the 256 switch values and comparing the digits with values the bench works out by division. The bench also checks a pulse just shorter than the debounce window and confirms that the count does not move.

// File: rtl/pbtn_counter_pkg.sv
package pbtn_counter_pkg;
  localparam int unsigned NUM_BTN = 4;
  localparam int unsigned BTN_CLR  = 0;
  localparam int unsigned BTN_LOAD = 1;
  localparam int unsigned BTN_UP   = 2;
  localparam int unsigned BTN_DOWN = 3;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_CLR,
    CMD_LOAD,
    CMD_UP,
    CMD_DOWN
  } cmd_e;
endpackage

// File: rtl/pbtn_debounce.sv
module pbtn_debounce #(
  parameter int unsigned DEBOUNCE_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_CYCLES - 1);

  logic          sync1_q, sync2_q;
  logic          level_q, level_d;
  logic          level_dly_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (sync2_q != level_q) begin
      if (cnt_q == LIMIT) begin
        level_d = sync2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q     <= 1'b0;
      level_dly_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      level_q     <= level_d;
      level_dly_q <= level_q;
      cnt_q       <= cnt_d;
    end
  end

  assign press_o = level_q & ~level_dly_q;

  // R7
  stable_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(sync2_q) == level_q));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/pbtn_count_core.sv
module pbtn_count_core
  import pbtn_counter_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [NUM_BTN-1:0] press_i,
  input  logic [WIDTH-1:0] sw_i,
  output logic [WIDTH-1:0] count_o
);
  cmd_e             cmd;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (press_i[BTN_CLR])       cmd = CMD_CLR;
    else if (press_i[BTN_LOAD]) cmd = CMD_LOAD;
    else if (press_i[BTN_UP])   cmd = CMD_UP;
    else if (press_i[BTN_DOWN]) cmd = CMD_DOWN;
    else                        cmd = CMD_NONE;
  end

  always_comb begin
    cnt_en = 1'b1;
    unique case (cmd)
      CMD_CLR:  cnt_d = '0;
      CMD_LOAD: cnt_d = sw_i;
      CMD_UP:   cnt_d = cnt_q + 1'b1;
      CMD_DOWN: cnt_d = cnt_q - 1'b1;
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    press_i[BTN_CLR] |=> (count_o == '0));
  // R5
  load_sw_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (press_i[BTN_LOAD] && !press_i[BTN_CLR]) |=> (count_o == $past(sw_i)));
  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (press_i == NUM_BTN'(1 << BTN_UP)) |=> (count_o == WIDTH'($past(count_o) + 1'b1)));
  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (press_i == NUM_BTN'(1 << BTN_DOWN)) |=> (count_o == WIDTH'($past(count_o) - 1'b1)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (press_i == '0) |=> $stable(count_o));
endmodule

// File: rtl/pbtn_bcd_conv.sv
module pbtn_bcd_conv #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned DIGITS = 3
) (
  input  logic [WIDTH-1:0]    bin_i,
  output logic [DIGITS*4-1:0] bcd_o
);
  localparam int unsigned SW = DIGITS * 4 + WIDTH;

  logic [SW-1:0] scratch;

  always_comb begin
    scratch = {{(DIGITS*4){1'b0}}, bin_i};
    for (int b = 0; b < WIDTH; b++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (scratch[WIDTH + d*4 +: 4] >= 4'd5) begin
          scratch[WIDTH + d*4 +: 4] = scratch[WIDTH + d*4 +: 4] + 4'd3;
        end
      end
      scratch = scratch << 1;
    end
    bcd_o = scratch[SW-1:WIDTH];
  end

  // R9
  always_comb begin
    bcd_digit_chk: assert (bcd_o[3:0] <= 4'd9 && bcd_o[7:4] <= 4'd9);
  end
endmodule

// File: rtl/pbtn_counter.sv
module pbtn_counter
  import pbtn_counter_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_up_i,
  input  logic       btn_down_i,
  input  logic       btn_load_i,
  input  logic       btn_clr_i,
  input  logic [7:0] sw_i,
  output logic [7:0] count_o,
  output logic [3:0] bcd_hund_o,
  output logic [3:0] bcd_tens_o,
  output logic [3:0] bcd_ones_o
);
  localparam int unsigned WIDTH  = 8;
  localparam int unsigned DIGITS = 3;

  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic [NUM_BTN-1:0] raw_btn;
  logic [NUM_BTN-1:0] press;
  logic [DIGITS*4-1:0] bcd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_comb begin
    raw_btn           = '0;
    raw_btn[BTN_CLR]  = btn_clr_i;
    raw_btn[BTN_LOAD] = btn_load_i;
    raw_btn[BTN_UP]   = btn_up_i;
    raw_btn[BTN_DOWN] = btn_down_i;
  end

  for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
    pbtn_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) i_deb (
      .clk    (clk),
      .rst_ni (rst_ni),
      .raw_i  (raw_btn[g]),
      .press_o(press[g])
    );
  end

  pbtn_count_core #(.WIDTH(WIDTH)) i_core (
    .clk    (clk),
    .rst_ni (rst_ni),
    .press_i(press),
    .sw_i   (sw_i),
    .count_o(count_o)
  );

  pbtn_bcd_conv #(.WIDTH(WIDTH), .DIGITS(DIGITS)) i_bcd (
    .bin_i(count_o),
    .bcd_o(bcd)
  );

  assign bcd_hund_o = bcd[11:8];
  assign bcd_tens_o = bcd[7:4];
  assign bcd_ones_o = bcd[3:0];

  // R9
  bcd_value_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (10'(bcd_hund_o) * 10'd100 + 10'(bcd_tens_o) * 10'd10 + 10'(bcd_ones_o)) == 10'(count_o));
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_ni |-> (count_o == 8'd0));
endmodule

// File: tb/test_pbtn_counter.sv
module test_pbtn_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 6;
  localparam int HOLD = DEB + 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up, dn, ld, clr;
  logic [7:0] sw;
  logic [7:0] count;
  logic [3:0] hund, tens, ones;

  int errors = 0;
  int checks = 0;
  int expv = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbtn_counter #(.DEBOUNCE_CYCLES(DEB)) i_pbtn_counter (
    .clk(clk), .rst_n(rst_n),
    .btn_up_i(up), .btn_down_i(dn), .btn_load_i(ld), .btn_clr_i(clr),
    .sw_i(sw), .count_o(count),
    .bcd_hund_o(hund), .bcd_tens_o(tens), .bcd_ones_o(ones)
  );

  task automatic check(input string req);
    checks++;
    if (count !== 8'(expv) || hund !== 4'(expv / 100) ||
        tens !== 4'((expv / 10) % 10) || ones !== 4'(expv % 10)) begin
      errors++;
      $display("FAIL %s: count=%0d bcd=%0d%0d%0d expected=%0d", req, count, hund, tens, ones, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] m, input int len);
    @(negedge clk);
    {clr, ld, up, dn} = m;
    idle(len);
    {clr, ld, up, dn} = 4'b0;
    idle(HOLD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; up = 0; dn = 0; ld = 0; clr = 0; sw = 8'd0;
    idle(3);
    expv = 0; check("R1 in reset");
    rst_n = 1'b1;
    idle(6);
    check("R1 after release");

    press(4'b0010, HOLD); expv = 1; check("R2 up");
    press(4'b0010, HOLD * 5); expv = 2; check("R2 long hold counts once");
    press(4'b0001, HOLD); expv = 1; check("R3 down");
    press(4'b0001, HOLD); expv = 0; check("R3 down to zero");
    press(4'b0001, HOLD); expv = 255; check("R4 wrap down");
    press(4'b0010, HOLD); expv = 0; check("R4 wrap up");

    sw = 8'd173;
    press(4'b0100, HOLD); expv = 173; check("R5 load");
    press(4'b1000, HOLD); expv = 0; check("R6 clear");

    press(4'b0010, DEB - 2); check("R7 short up ignored");
    press(4'b0100, DEB - 1); check("R7 short load ignored");
    press(4'b0010, DEB + 1); expv = 1; check("R7 long enough accepted");

    sw = 8'd90;
    press(4'b0110, HOLD); expv = 90; check("R8 load beats up");
    press(4'b0011, HOLD); expv = 91; check("R8 up beats down");
    press(4'b1100, HOLD); expv = 0; check("R8 clear beats load");
    sw = 8'd200;
    press(4'b0101, HOLD); expv = 200; check("R8 load beats down");
    press(4'b1011, HOLD); expv = 0; check("R8 clear beats up and down");

    for (int v = 0; v < 256; v++) begin
      sw = 8'(v);
      press(4'b0100, DEB + 2);
      expv = v;
      check("R9 bcd sweep");
    end

    rst_n = 1'b0;
    idle(2);
    expv = 0; check("R1 async reset");
    rst_n = 1'b1;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule